// File: doc/BRIEF.md
# Programmable Timer Channel with PWM Output

This block is one timer channel. A 16-bit counter steps once per divided clock. The clock divider is a power-of-two prescaler set by a 4-bit field N, which gives one counter step every 2^(N+1) input clocks. The counter runs up or down. It either wraps at a programmed interval limit or uses the full 16-bit range. The channel compares the count against three match registers and against zero. Each comparison sets its own sticky flag, and a mask chosen by software decides which flags drive the interrupt line. The first match register also sets the duty point of a PWM waveform, whose polarity is selectable.

Software programs the channel through a simple write port of address, data and strobe. The counter runs while the run bit is set. Clearing the run bit stops the channel and clears the counter. Writes to the interval and match registers first go into holding registers. They reach the compare logic when the counter is stopped, or at the next period restart, so a PWM period already in progress keeps its shape. A combinational read port returns the live count or the status flags. A read of the status address with the read strobe clears the flags.

Top module: `tmr_pwm_chan`

## Requirements
- R1: Write address 0 holds control: bit0 run, bit1 interval mode, bit2 count down, bit3 PWM polarity, bits7:4 prescale N. While running, the count changes only every 2^(N+1) input clocks, for every N from 0 to 15. The first step lands 2^(N+1) clocks after the edge that sets the run bit.
- R2: When interval mode is on, counting up, and the interval register (write address 1) is nonzero, the count goes from the interval value back to 0 and counting continues.
- R3: When interval mode is on and the interval register is zero, the count runs the full 0 to 0xFFFF range.
- R4: When interval mode is off, the interval register is ignored and the count cycles through 0 to 0xFFFF.
- R5: When counting down, a step from 0 reloads the limit: the interval value in interval mode, and 0xFFFF when interval mode is off.
- R6: While the run bit is clear, the count reads 0, the prescaler is cleared, and the PWM output sits at the polarity level.
- R7: On each step where the new count equals match 1 (write address 2), the PWM output is driven to the inverse of polarity. On each restart step it returns to polarity. If both happen on the same step, the match wins.
- R8: Status (read address 1) holds sticky flags: bit0 zero, bit1 match 1, bit2 match 2 (write address 3), bit3 match 3 (write address 4). A flag is set on a counter step whose new count equals its compare value, and is never set on any other clock.
- R9: A status read with the read strobe clears all flags. A flag whose event falls in that same cycle stays set.
- R10: The interrupt output is the OR of the flags masked by the enable bits at write address 5, which use the same bit order as status.
- R11: New interval and match values take effect immediately while the channel is stopped. While it runs, they take effect at the next restart, and the period in progress keeps the old values.
- R12: After reset the count, status, interrupt and PWM output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Read strobe; clears status when rd_addr selects status |
| rd_addr | input | 3 | Read select: 0 count, 1 status |
| rd_data | output | 16 | Read data, combinational |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
A clearing status read and a new compare event can land on the same clock edge. The set must win. The bench raises the read strobe in the clock just before the counter step that reaches match 1, while the zero flag is already pending. It then expects the read data of that cycle to show only the zero flag, and the status after the edge to show only the match 1 flag. A restart and a match 1 hit can also coincide when match 1 is zero. That case is judged by the PWM level held after the restart step.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CNT_W     = 16;
  localparam int PS_W      = 4;
  localparam int NUM_MATCH = 3;
  localparam int ADDR_W    = 3;
  localparam int PRE_W     = 1 << PS_W;
  localparam int NSRC      = NUM_MATCH + 1;

  localparam int A_CTRL   = 0;
  localparam int A_INTV   = 1;
  localparam int A_MATCH0 = 2;
  localparam int A_IRQEN  = A_MATCH0 + NUM_MATCH;
  localparam int A_COUNT  = 0;
  localparam int A_STAT   = 1;

  typedef struct packed {
    logic [PS_W-1:0] pscale;
    logic            pol;
    logic            down;
    logic            intv_mode;
    logic            run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // last prescaler value of a divide-by-2^(n+1) cycle
  function automatic logic [PRE_W-1:0] prescale_term(input logic [PS_W-1:0] n);
    logic [PRE_W:0] w;
    w = (PRE_W+1)'(1) << (int'(n) + 1);
    w = w - (PRE_W+1)'(1);
    return w[PRE_W-1:0];
  endfunction

  // wrap limit actually used by the counter
  function automatic logic [CNT_W-1:0] eff_limit(input logic mode,
                                                 input logic [CNT_W-1:0] v);
    return (mode && (v != '0)) ? v : '1;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int P_PS_W  = PS_W,
  parameter int P_PRE_W = PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [P_PS_W-1:0] pscale,
  output logic              tick
);
  logic [P_PRE_W-1:0] div_q;
  logic [P_PRE_W-1:0] term;

  assign term = P_PRE_W'(prescale_term(PS_W'(pscale)));
  assign tick = run && (div_q >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (!run || tick) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core #(
  parameter int P_CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               down,
  input  logic [P_CNT_W-1:0] lim_act,
  input  logic [P_CNT_W-1:0] lim_new,
  output logic [P_CNT_W-1:0] cnt,
  output logic [P_CNT_W-1:0] cnt_next,
  output logic               step,
  output logic               restart
);
  logic wrap;

  always_comb begin
    if (down) begin
      wrap     = (cnt == '0);
      cnt_next = wrap ? lim_new : cnt - 1'b1;
    end else begin
      wrap     = (cnt == lim_act);
      cnt_next = wrap ? '0 : cnt + 1'b1;
    end
  end

  assign step    = run && tick;
  assign restart = step && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= cnt_next;
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
`timescale 1ns/1ps
module tmr_irq_ctrl #(
  parameter int P_NSRC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P_NSRC-1:0] ev,
  input  logic              clr,
  input  logic [P_NSRC-1:0] en,
  output logic [P_NSRC-1:0] flags,
  output logic              irq
);
  for (genvar i = 0; i < P_NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flags[i] <= 1'b0;
      else if (ev[i]) flags[i] <= 1'b1;
      else if (clr)   flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & en);
endmodule

// File: rtl/tmr_pwm_chan.sv
`timescale 1ns/1ps
module tmr_pwm_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              pwm_out,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] intv_pend, intv_act;
  logic [CNT_W-1:0] m_pend [NUM_MATCH];
  logic [CNT_W-1:0] m_act  [NUM_MATCH];
  logic [CNT_W-1:0] cmp_m  [NUM_MATCH];
  logic [NSRC-1:0]  irq_en_q;
  logic [NSRC-1:0]  ev;
  logic [NSRC-1:0]  flags;
  logic [CNT_W-1:0] cnt, cnt_next, lim_act, lim_new;
  logic             tick, step, restart, load_act, rd_clr, pwm_q;

  // control, interval and enable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      intv_pend <= '0;
      irq_en_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CTRL))  ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == ADDR_W'(A_INTV))  intv_pend <= wr_data;
      if (wr_addr == ADDR_W'(A_IRQEN)) irq_en_q  <= wr_data[NSRC-1:0];
    end
  end

  // match holding registers and their active copies
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_pend[i] <= '0;
        m_act[i]  <= '0;
      end else begin
        if (wr_en && (wr_addr == ADDR_W'(A_MATCH0 + i))) m_pend[i] <= wr_data;
        if (load_act) m_act[i] <= m_pend[i];
      end
    end
    assign cmp_m[i] = restart ? m_pend[i] : m_act[i];
    assign ev[i+1]  = step && (cnt_next == cmp_m[i]);
  end

  assign load_act = !ctrl_q.run || restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        intv_act <= '0;
    else if (load_act) intv_act <= intv_pend;
  end

  assign lim_act = eff_limit(ctrl_q.intv_mode, intv_act);
  assign lim_new = eff_limit(ctrl_q.intv_mode, intv_pend);

  tmr_prescaler #(.P_PS_W(PS_W), .P_PRE_W(PRE_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .pscale(ctrl_q.pscale),
    .tick(tick)
  );

  tmr_count_core #(.P_CNT_W(CNT_W)) i_core (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick(tick),
    .down(ctrl_q.down), .lim_act(lim_act), .lim_new(lim_new),
    .cnt(cnt), .cnt_next(cnt_next), .step(step), .restart(restart)
  );

  assign ev[0] = step && (cnt_next == '0);

  assign rd_clr = rd_en && (rd_addr == ADDR_W'(A_STAT));

  tmr_irq_ctrl #(.P_NSRC(NSRC)) i_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(rd_clr), .en(irq_en_q),
    .flags(flags), .irq(irq)
  );

  // PWM: match 1 flips, restart restores, match has priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pwm_q <= 1'b0;
    else if (!ctrl_q.run)    pwm_q <= ctrl_q.pol;
    else if (ev[1])          pwm_q <= ~ctrl_q.pol;
    else if (restart)        pwm_q <= ctrl_q.pol;
  end
  assign pwm_out = pwm_q;

  always_comb begin
    if (rd_addr == ADDR_W'(A_COUNT))     rd_data = cnt;
    else if (rd_addr == ADDR_W'(A_STAT)) rd_data = {{(CNT_W-NSRC){1'b0}}, flags};
    else                                 rd_data = '0;
  end
endmodule

// File: rtl/tmr_pwm_chan_chk.sv
`timescale 1ns/1ps
module tmr_pwm_chan_chk #(
  parameter int P_CNT_W = 16,
  parameter int P_NSRC  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               tick,
  input logic               down,
  input logic               intv_mode,
  input logic [P_CNT_W-1:0] cnt,
  input logic [P_CNT_W-1:0] lim_act,
  input logic               rd_clr,
  input logic [P_NSRC-1:0]  flags,
  input logic               pwm
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  p_wrap_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !down && (cnt == lim_act)) |=> (cnt == '0));

  p_ovf_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && down && !intv_mode && (cnt == '0)) |=> (cnt == '1));

  p_stop_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  p_pwm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(pwm));

  p_flag_on_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((flags & ~$past(flags)) == '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !tick) |=> (flags == '0));
endmodule

bind tmr_pwm_chan tmr_pwm_chan_chk #(.P_CNT_W(tmr_pkg::CNT_W), .P_NSRC(tmr_pkg::NSRC)) i_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick(tick), .down(ctrl_q.down),
  .intv_mode(ctrl_q.intv_mode), .cnt(cnt), .lim_act(lim_act), .rd_clr(rd_clr),
  .flags(flags), .pwm(pwm_q)
);

// File: tb/test_tmr_pwm_chan.sv
`timescale 1ns/1ps
module test_tmr_pwm_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm_out, irq;

  int checks = 0, failures = 0;
  int cyc = 0;
  int t0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_pwm_chan i_tmr_pwm_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  n;
    logic        intv;
    logic        down;
    logic [15:0] ival;
    logic [31:0] clocks;
    logic [15:0] exp;
  } vec_t;

  // R4 ovf ignores interval, R2 wrap, R1 N=2, R5 down interval, R5 down ovf,
  // R3 interval zero, R1 N=15 boundary
  localparam vec_t VEC [8] = '{
    '{4'd0,  1'b0, 1'b0, 16'd5, 32'd20,    16'd10},
    '{4'd0,  1'b1, 1'b0, 16'd5, 32'd20,    16'd4},
    '{4'd2,  1'b1, 1'b0, 16'd3, 32'd80,    16'd2},
    '{4'd0,  1'b1, 1'b1, 16'd5, 32'd20,    16'd2},
    '{4'd0,  1'b0, 1'b1, 16'd5, 32'd6,     16'hFFFD},
    '{4'd0,  1'b1, 1'b0, 16'd0, 32'd20,    16'd10},
    '{4'd15, 1'b0, 1'b0, 16'd0, 32'd65535, 16'd0},
    '{4'd15, 1'b0, 1'b0, 16'd0, 32'd65536, 16'd1}
  };

  function automatic logic [15:0] ctrl_word(input logic [3:0] n, input logic pol,
                                             input logic down, input logic intv,
                                             input logic run);
    return {8'h00, n, pol, down, intv, run};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_abs(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic rd_clear();
    rd_addr = 3'd1; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R12 reset state
    rd(3'd0, v); chk("R12 count", v, 16'd0);
    rd(3'd1, v); chk("R12 status", v, 16'd0);
    chk("R12 pwm", {15'd0, pwm_out}, 16'd0);
    chk("R12 irq", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: count value after a number of clocks
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 16'd0);
      wr(3'd1, VEC[i].ival);
      wr(3'd0, ctrl_word(VEC[i].n, 1'b0, VEC[i].down, VEC[i].intv, 1'b1));
      t0 = cyc;
      wait_abs(t0 + int'(VEC[i].clocks));
      rd(3'd0, v);
      chk($sformatf("vec%0d R1 R2 R3 R4 R5 count", i), v, VEC[i].exp);
    end

    // R6 stopped state, polarity 1 idle level
    wr(3'd0, ctrl_word(4'd0, 1'b1, 1'b0, 1'b1, 1'b0));
    @(negedge clk);
    rd(3'd0, v); chk("R6 stopped count", v, 16'd0);
    chk("R6 idle pwm pol1", {15'd0, pwm_out}, 16'd1);

    // R7 PWM with pol 1 and R11 shadowed update mid period
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd3);
    wr(3'd0, ctrl_word(4'd0, 1'b1, 1'b0, 1'b1, 1'b1));
    t0 = cyc;
    wait_abs(t0 + 4);  chk("R7 pwm before match", {15'd0, pwm_out}, 16'd1);
    wait_abs(t0 + 6);  chk("R7 pwm at match1", {15'd0, pwm_out}, 16'd0);
    wait_abs(t0 + 10);
    wr(3'd1, 16'd4);
    wr(3'd2, 16'd1);
    wait_abs(t0 + 18);
    rd(3'd0, v); chk("R11 old interval kept", v, 16'd9);
    chk("R7 pwm low late", {15'd0, pwm_out}, 16'd0);
    wait_abs(t0 + 20);
    rd(3'd0, v); chk("R11 restart count", v, 16'd0);
    chk("R7 pwm restored", {15'd0, pwm_out}, 16'd1);
    wait_abs(t0 + 22); chk("R11 new match1", {15'd0, pwm_out}, 16'd0);
    wait_abs(t0 + 30);
    rd(3'd0, v); chk("R11 new interval wrap", v, 16'd0);
    chk("R7 pwm restored new period", {15'd0, pwm_out}, 16'd1);

    // R7 polarity 0
    wr(3'd0, ctrl_word(4'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd3);
    chk("R6 idle pwm pol0", {15'd0, pwm_out}, 16'd0);
    wr(3'd0, ctrl_word(4'd0, 1'b0, 1'b0, 1'b1, 1'b1));
    t0 = cyc;
    wait_abs(t0 + 4);  chk("R7 pol0 before match", {15'd0, pwm_out}, 16'd0);
    wait_abs(t0 + 6);  chk("R7 pol0 at match", {15'd0, pwm_out}, 16'd1);
    wait_abs(t0 + 20); chk("R7 pol0 restart", {15'd0, pwm_out}, 16'd0);

    // R7 match1 = 0 wins over restart
    wr(3'd0, ctrl_word(4'd0, 1'b1, 1'b0, 1'b1, 1'b0));
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd0);
    wr(3'd0, ctrl_word(4'd0, 1'b1, 1'b0, 1'b1, 1'b1));
    t0 = cyc;
    wait_abs(t0 + 6);  chk("R7 m1zero mid", {15'd0, pwm_out}, 16'd1);
    wait_abs(t0 + 8);  chk("R7 m1zero restart", {15'd0, pwm_out}, 16'd0);

    // R8 R9 R10 flags, masking and clear collision
    wr(3'd0, ctrl_word(4'd0, 1'b1, 1'b0, 1'b1, 1'b0));
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd5);
    wr(3'd4, 16'd7);
    wr(3'd5, 16'h0008);
    @(negedge clk);
    rd_clear();
    rd(3'd1, v); chk("R9 cleared before run", v, 16'd0);
    wr(3'd0, ctrl_word(4'd0, 1'b1, 1'b0, 1'b1, 1'b1));
    t0 = cyc;
    wait_abs(t0 + 12);
    rd(3'd1, v); chk("R8 match1 match2 flags", v, 16'h0006);
    chk("R10 masked irq", {15'd0, irq}, 16'd0);
    rd_clear();
    rd(3'd1, v); chk("R9 read clears", v, 16'd0);
    wait_abs(t0 + 16);
    rd(3'd1, v); chk("R8 match3 flag", v, 16'h0008);
    chk("R10 enabled irq", {15'd0, irq}, 16'd1);
    rd_clear();
    chk("R10 irq after clear", {15'd0, irq}, 16'd0);
    wait_abs(t0 + 20);
    rd(3'd1, v); chk("R8 zero flag", v, 16'h0001);
    wait_abs(t0 + 25);
    rd_addr = 3'd1; rd_en = 1'b1; #1;
    chk("R9 collision read data", rd_data, 16'h0001);
    @(negedge clk);
    rd_en = 1'b0;
    rd(3'd1, v); chk("R9 set wins over clear", v, 16'h0002);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule